// File: doc/BRIEF.md
# Dual Reload Timer Pair

Two 16-bit timer/counters, each held as a low byte and a high byte and each driven by its own configuration: a 2-bit mode, a choice between the shared internal tick strobe and its own external event strobe, a gate enable and a run bit. Each timer has a 16-bit reload value kept as two bytes, an overflow flag, and a toggle pin that can take the place of the flag. Software configures the pair through a byte-wide write port. It reads back the configuration, the counts and the flags through a combinational read port.

The four modes are: a 16-bit count that reloads from the reload bytes, a free 16-bit count, an 8-bit low-byte count that reloads the low byte, and a fourth mode. In the fourth mode timer 1 stops. Timer 0 becomes two 8-bit counters, and its high byte takes over timer 1's run bit and overflow channel. Interrupt-acknowledge inputs clear the flags from outside.

Top module: `dual_reload_timer`

Register map (4-bit address, 8-bit data): 0 config (timer 0 in bits 3:0, timer 1 in bits 7:4; within a nibble bits 1:0 mode, bit 2 event select, bit 3 gate); 1 run and flags (bit 0 run0, bit 1 run1, bit 2 flag0, bit 3 flag1); 2 toggle enables (bit 0 timer 0, bit 1 timer 1); 3/4 timer 0 count low/high; 5/6 timer 1 count low/high; 7/8 timer 0 reload low/high; 9/10 timer 1 reload low/high. Any other address reads zero.

## Requirements
- R1: After reset every register reads zero and both flags and both toggle pins are low.
- R2: In mode 0 (code 00), a count step from FFFF loads the count with {reload high, reload low} and sets the flag. Any other step adds one across 16 bits.
- R3: In mode 1 (code 01), the 16-bit count adds one per step, wraps from FFFF to 0000 and sets the flag on that wrap.
- R4: In mode 2 (code 10), only the low byte counts. A step from FF loads it from reload low and sets the flag, and the high byte never changes.
- R5: Timer 1 in mode 3 (code 11) holds its count and raises no overflow.
- R6: With timer 0 in mode 3, its low byte counts with timer 0's controls, wraps to 00 and sets flag 0. Its high byte counts internal ticks while run1 is set, and its wrap alone drives flag 1 and toggle pin 1. Timer 1 then counts regardless of run1, but its overflow is discarded.
- R7: With gate set, a timer counts only while its gate pin is high and its run bit is set. With gate clear, the run bit alone enables it.
- R8: With event select clear a timer counts internal ticks and ignores its event strobe. With it set, the timer counts event strobes and ignores ticks.
- R9: With a timer's toggle enable set, each of its overflows inverts its toggle pin and leaves its flag unchanged.
- R10: A flag stays set until a write to address 1 with that flag's bit at 0 or a pulse on its acknowledge input clears it. Writing 1 to the bit leaves it unchanged, and an overflow in the same cycle as a clear leaves it set.
- R11: A write to either count byte of a timer takes effect on the next edge and suppresses that timer's count step in that cycle. Reload and configuration registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Internal tick strobe from the prescaler |
| evt_i | input | 2 | External event strobes, one per timer |
| gate_pin_i | input | 2 | External gate pins, one per timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| irq_ack_i | input | 2 | Flag clear from the interrupt acknowledge, one per channel |
| ovf_flag_o | output | 2 | Overflow flags |
| tog_o | output | 2 | Toggle-on-overflow pins |

## Verification
The reload mode is tried with a start value one step below its wrap and with a value that only carries from the low byte into the high byte. This separates a reload from a plain increment. Each mode is driven at its wrap point and just before it, so the reload value, the wrap to zero, the untouched high byte and the split low byte each give a distinct count. Gate, source select, toggle and clear priority are each flipped between two otherwise identical steps. The result then shows whether that control alone decided the outcome.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_RELOAD16 = 2'd0,
    MD_FREE16   = 2'd1,
    MD_RELOAD8  = 2'd2,
    MD_SPLIT    = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      evt_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam int A_CFG    = 0;
  localparam int A_RUNFLG = 1;
  localparam int A_TOGEN  = 2;
  localparam int A_CNT0L  = 3;
  localparam int A_RLD0L  = 7;
  localparam int N_TMR    = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DW-1:0]                wr_data,
  output tmr_cfg_t [N_TMR-1:0]         cfg_o,
  output logic [N_TMR-1:0]             run_o,
  output logic [N_TMR-1:0]             tog_en_o,
  output logic [N_TMR-1:0][DW-1:0]     rld_lo_o,
  output logic [N_TMR-1:0][DW-1:0]     rld_hi_o,
  output logic [N_TMR-1:0]             flag_clr_o,
  output logic [N_TMR-1:0]             cnt_wr_lo_o,
  output logic [N_TMR-1:0]             cnt_wr_hi_o
);
  localparam logic [AW-1:0] ADDR_CFG    = AW'(A_CFG);
  localparam logic [AW-1:0] ADDR_RUNFLG = AW'(A_RUNFLG);
  localparam logic [AW-1:0] ADDR_TOGEN  = AW'(A_TOGEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o    <= '0;
      run_o    <= '0;
      tog_en_o <= '0;
      rld_lo_o <= '0;
      rld_hi_o <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CFG)    cfg_o    <= wr_data;
      if (wr_addr == ADDR_RUNFLG) run_o    <= wr_data[N_TMR-1:0];
      if (wr_addr == ADDR_TOGEN)  tog_en_o <= wr_data[N_TMR-1:0];
      for (int n = 0; n < N_TMR; n++) begin
        if (wr_addr == AW'(A_RLD0L + 2*n))     rld_lo_o[n] <= wr_data;
        if (wr_addr == AW'(A_RLD0L + 2*n + 1)) rld_hi_o[n] <= wr_data;
      end
    end
  end

  // Write-side strobes consumed by the counters and flag units.
  always_comb begin
    for (int n = 0; n < N_TMR; n++) begin
      flag_clr_o[n]  = wr_en && (wr_addr == ADDR_RUNFLG) && !wr_data[N_TMR+n];
      cnt_wr_lo_o[n] = wr_en && (wr_addr == AW'(A_CNT0L + 2*n));
      cnt_wr_hi_o[n] = wr_en && (wr_addr == AW'(A_CNT0L + 2*n + 1));
    end
  end

  p_cfg_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CFG) |=> (cfg_o == $past(wr_data)));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int DW       = 8,
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_mode_e     mode,
  input  logic          lo_en,
  input  logic          hi_en,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rld_lo,
  input  logic [DW-1:0] rld_hi,
  output logic [DW-1:0] cnt_lo_o,
  output logic [DW-1:0] cnt_hi_o,
  output logic          ovf_main_o,
  output logic          ovf_split_o
);
  localparam int WW = 2 * DW;

  function automatic logic [DW:0] step_b(input logic [DW-1:0] v);
    return {&v, v + 1'b1};
  endfunction

  function automatic logic [WW:0] step_w(input logic [WW-1:0] v);
    return {&v, v + 1'b1};
  endfunction

  logic [DW-1:0] nlo, nhi;
  logic [DW:0]   lo_step, hi_step;
  logic [WW:0]   w_step;
  logic          wr_any;

  assign wr_any  = wr_lo || wr_hi;
  assign lo_step = step_b(cnt_lo_o);
  assign hi_step = step_b(cnt_hi_o);
  assign w_step  = step_w({cnt_hi_o, cnt_lo_o});

  always_comb begin
    nlo         = cnt_lo_o;
    nhi         = cnt_hi_o;
    ovf_main_o  = 1'b0;
    ovf_split_o = 1'b0;
    if (wr_any) begin
      if (wr_lo) nlo = wr_data;
      if (wr_hi) nhi = wr_data;
    end else begin
      unique case (mode)
        MD_RELOAD16: if (lo_en) begin
          ovf_main_o = w_step[WW];
          if (w_step[WW]) {nhi, nlo} = {rld_hi, rld_lo};
          else            {nhi, nlo} = w_step[WW-1:0];
        end
        MD_FREE16: if (lo_en) begin
          ovf_main_o = w_step[WW];
          {nhi, nlo} = w_step[WW-1:0];
        end
        MD_RELOAD8: if (lo_en) begin
          ovf_main_o = lo_step[DW];
          nlo        = lo_step[DW] ? rld_lo : lo_step[DW-1:0];
        end
        MD_SPLIT: if (SPLIT_OK) begin
          if (lo_en) begin
            ovf_main_o = lo_step[DW];
            nlo        = lo_step[DW-1:0];
          end
          if (hi_en) begin
            ovf_split_o = hi_step[DW];
            nhi         = hi_step[DW-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lo_o <= '0;
      cnt_hi_o <= '0;
    end else begin
      cnt_lo_o <= nlo;
      cnt_hi_o <= nhi;
    end
  end

  p_reload16_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RELOAD16 && lo_en && !wr_any && (&{cnt_hi_o, cnt_lo_o}))
      |=> ({cnt_hi_o, cnt_lo_o} == $past({rld_hi, rld_lo})));

  p_free_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FREE16 && lo_en && !wr_any && (&{cnt_hi_o, cnt_lo_o}))
      |=> ({cnt_hi_o, cnt_lo_o} == '0));

  p_rl8_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RELOAD8 && !wr_any) |=> $stable(cnt_hi_o));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_en && !hi_en && !wr_any) |=> $stable({cnt_hi_o, cnt_lo_o}));

  p_wr_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo_o == $past(wr_data)));

  generate
    if (!SPLIT_OK) begin : g_stop
      p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SPLIT && !wr_any) |=> ($stable({cnt_hi_o, cnt_lo_o}) && !$past(ovf_main_o)));
    end
  endgenerate
endmodule

// File: rtl/tmr_event.sv
module tmr_event (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic tog_en,
  input  logic sw_clr,
  input  logic ack,
  output logic flag_o,
  output logic pin_o
);
  logic set_ev, tog_ev, clr_ev;

  assign set_ev = ovf && !tog_en;
  assign tog_ev = ovf && tog_en;
  assign clr_ev = sw_clr || ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      pin_o  <= 1'b0;
    end else begin
      if (set_ev)      flag_o <= 1'b1;
      else if (clr_ev) flag_o <= 1'b0;
      if (tog_ev)      pin_o  <= ~pin_o;
    end
  end

  p_tog_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && tog_en) |=> (pin_o != $past(pin_o)));

  p_tog_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && tog_en) |=> (flag_o == $past(flag_o) || !flag_o));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !tog_en) |=> flag_o);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_clr || ack) && !ovf) |=> !flag_o);
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import tmr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [1:0]    evt_i,
  input  logic [1:0]    gate_pin_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [1:0]    irq_ack_i,
  output logic [1:0]    ovf_flag_o,
  output logic [1:0]    tog_o
);
  tmr_cfg_t [N_TMR-1:0]     cfg;
  logic [N_TMR-1:0]         run, tog_en, flag_clr, cnt_wr_lo, cnt_wr_hi;
  logic [N_TMR-1:0][DW-1:0] rld_lo, rld_hi, cnt_lo, cnt_hi;
  logic [N_TMR-1:0]         src, gate_ok, lo_en, hi_en, ovf_main, ovf_split, chan_ev;
  logic                     split;

  tmr_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk, .rst_n,
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .cfg_o(cfg), .run_o(run), .tog_en_o(tog_en),
    .rld_lo_o(rld_lo), .rld_hi_o(rld_hi),
    .flag_clr_o(flag_clr), .cnt_wr_lo_o(cnt_wr_lo), .cnt_wr_hi_o(cnt_wr_hi)
  );

  assign split = (cfg[0].mode == MD_SPLIT);

  // Run qualification: source pick, gate, and run bit (timer 1 loses its run bit while split).
  always_comb begin
    for (int n = 0; n < N_TMR; n++) begin
      src[n]     = cfg[n].evt_sel ? evt_i[n] : tick_i;
      gate_ok[n] = !cfg[n].gate || gate_pin_i[n];
    end
    lo_en[0] = run[0] && gate_ok[0] && src[0];
    hi_en[0] = split && run[1] && tick_i;
    lo_en[1] = (split || run[1]) && gate_ok[1] && src[1];
    hi_en[1] = 1'b0;
  end

  // Channel 1 is fed by timer 0's high byte while split.
  assign chan_ev[0] = ovf_main[0];
  assign chan_ev[1] = split ? ovf_split[0] : ovf_main[1];

  generate
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
      tmr_core #(.DW(DW), .SPLIT_OK(g == 0)) u_core (
        .clk, .rst_n,
        .mode(cfg[g].mode), .lo_en(lo_en[g]), .hi_en(hi_en[g]),
        .wr_lo(cnt_wr_lo[g]), .wr_hi(cnt_wr_hi[g]), .wr_data(wr_data_i),
        .rld_lo(rld_lo[g]), .rld_hi(rld_hi[g]),
        .cnt_lo_o(cnt_lo[g]), .cnt_hi_o(cnt_hi[g]),
        .ovf_main_o(ovf_main[g]), .ovf_split_o(ovf_split[g])
      );
      tmr_event u_evt (
        .clk, .rst_n,
        .ovf(chan_ev[g]), .tog_en(tog_en[g]),
        .sw_clr(flag_clr[g]), .ack(irq_ack_i[g]),
        .flag_o(ovf_flag_o[g]), .pin_o(tog_o[g])
      );
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(A_CFG))    rd_data_o = cfg;
    if (rd_addr_i == AW'(A_RUNFLG)) rd_data_o = DW'({ovf_flag_o, run});
    if (rd_addr_i == AW'(A_TOGEN))  rd_data_o = DW'(tog_en);
    for (int n = 0; n < N_TMR; n++) begin
      if (rd_addr_i == AW'(A_CNT0L + 2*n))     rd_data_o = cnt_lo[n];
      if (rd_addr_i == AW'(A_CNT0L + 2*n + 1)) rd_data_o = cnt_hi[n];
      if (rd_addr_i == AW'(A_RLD0L + 2*n))     rd_data_o = rld_lo[n];
      if (rd_addr_i == AW'(A_RLD0L + 2*n + 1)) rd_data_o = rld_hi[n];
    end
  end

  p_split_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !ovf_split[0]) |=> !$rose(ovf_flag_o[1]));

  p_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0].gate && !gate_pin_i[0] && !split && !cnt_wr_lo[0] && !cnt_wr_hi[0])
      |=> $stable({cnt_hi[0], cnt_lo[0]}));
endmodule

// File: tb/tb_dual_reload_timer.sv
module tb_dual_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [1:0] evt, gpin, ack;
  logic       wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [1:0] flag, tog;
  int         n_checks = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  dual_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .evt_i(evt), .gate_pin_i(gpin),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_ack_i(ack),
    .ovf_flag_o(flag), .tog_o(tog)
  );

  // mode[50:49] start[48:33] reload[32:17] expected[16:1] flag[0], timer 0
  localparam logic [50:0] VEC [8] = '{
    {2'd0, 16'hFFFF, 16'h1234, 16'h1234, 1'b1},
    {2'd0, 16'h00FF, 16'h1234, 16'h0100, 1'b0},
    {2'd1, 16'hFFFF, 16'h5555, 16'h0000, 1'b1},
    {2'd1, 16'h12FF, 16'h5555, 16'h1300, 1'b0},
    {2'd2, 16'h34FF, 16'h0056, 16'h3456, 1'b1},
    {2'd2, 16'h34FE, 16'h0056, 16'h34FF, 1'b0},
    {2'd3, 16'h12FF, 16'h0000, 16'h1200, 1'b1},
    {2'd0, 16'hABCD, 16'h0000, 16'hABCE, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic rd16(input int t, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(4'(3 + 2*t), lo);
    rd(4'(4 + 2*t), hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input int t, input logic [15:0] v);
    wr(4'(3 + 2*t), v[7:0]);
    wr(4'(4 + 2*t), v[15:8]);
  endtask

  task automatic set_rld(input int t, input logic [15:0] v);
    wr(4'(7 + 2*t), v[7:0]);
    wr(4'(8 + 2*t), v[15:8]);
  endtask

  task automatic pulse_tick;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    rst_n = 1'b0; tick = 1'b0; evt = '0; gpin = '0; ack = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), b);
      check("R1 reg", {8'h0, b}, 16'h0000);
    end
    check("R1 flags/pins", {12'h0, flag, tog}, 16'h0000);

    // Mode table on timer 0 (R2 R3 R4 R6)
    for (int i = 0; i < 8; i++) begin
      wr(8'h00, {6'b0, VEC[i][50:49]});
      set_rld(0, VEC[i][32:17]);
      set_cnt(0, VEC[i][48:33]);
      wr(8'h01, 8'h01);
      pulse_tick();
      rd16(0, v);
      check($sformatf("R2/R3/R4/R6 vec%0d count", i), v, VEC[i][16:1]);
      check($sformatf("R2/R3/R4/R6 vec%0d flag", i), {15'h0, flag[0]}, {15'h0, VEC[i][0]});
      wr(8'h01, 8'h00);
    end

    // R2: timer 1 reload path
    wr(8'h00, 8'h00);
    set_rld(1, 16'hBEEF);
    set_cnt(1, 16'hFFFF);
    wr(8'h01, 8'h02);
    pulse_tick();
    rd16(1, v);
    check("R2 timer1 reload", v, 16'hBEEF);
    check("R2 timer1 flag", {15'h0, flag[1]}, 16'h0001);
    wr(8'h01, 8'h00);

    // R5: timer 1 mode 3 holds
    wr(8'h00, 8'h30);
    set_cnt(1, 16'h1234);
    wr(8'h01, 8'h02);
    pulse_tick();
    rd16(1, v);
    check("R5 hold count", v, 16'h1234);
    check("R5 no flag", {15'h0, flag[1]}, 16'h0000);
    wr(8'h01, 8'h00);

    // R6: split timer 0, timer 1 in mode 1 wraps but is muted
    wr(8'h00, 8'h13);
    set_cnt(0, 16'h05FF);
    set_cnt(1, 16'hFFFF);
    wr(8'h01, 8'h03);
    pulse_tick();
    rd16(0, v);
    check("R6 split count", v, 16'h0600);
    check("R6 flags low wrap only", {14'h0, flag}, 16'h0001);
    rd16(1, v);
    check("R6 timer1 still counts", v, 16'h0000);
    wr(8'h04, 8'hFF);
    wr(8'h01, 8'h03);
    pulse_tick();
    rd16(0, v);
    check("R6 high wrap count", v, 16'h0001);
    check("R6 high wrap drives flag1", {14'h0, flag}, 16'h0002);
    wr(8'h01, 8'h00);

    // R7: gate
    wr(8'h00, 8'h09);
    set_cnt(0, 16'h0000);
    wr(8'h01, 8'h01);
    gpin[0] = 1'b0;
    pulse_tick();
    rd16(0, v);
    check("R7 gate pin low blocks", v, 16'h0000);
    gpin[0] = 1'b1;
    pulse_tick();
    rd16(0, v);
    check("R7 gate pin high counts", v, 16'h0001);
    gpin[0] = 1'b0;
    wr(8'h01, 8'h00);

    // R8: source select
    wr(8'h00, 8'h05);
    set_cnt(0, 16'h0000);
    wr(8'h01, 8'h01);
    pulse_tick();
    rd16(0, v);
    check("R8 tick ignored", v, 16'h0000);
    evt[0] = 1'b1;
    @(negedge clk);
    evt[0] = 1'b0;
    rd16(0, v);
    check("R8 event counted", v, 16'h0001);
    wr(8'h00, 8'h01);
    evt[0] = 1'b1;
    @(negedge clk);
    evt[0] = 1'b0;
    rd16(0, v);
    check("R8 event ignored in tick mode", v, 16'h0001);
    wr(8'h01, 8'h00);

    // R9: toggle pin replaces flag
    wr(8'h02, 8'h01);
    set_cnt(0, 16'hFFFF);
    wr(8'h01, 8'h01);
    pulse_tick();
    check("R9 pin rises, no flag", {14'h0, tog[0], flag[0]}, 16'h0002);
    set_cnt(0, 16'hFFFF);
    pulse_tick();
    check("R9 pin falls, no flag", {14'h0, tog[0], flag[0]}, 16'h0000);
    wr(8'h02, 8'h00);

    // R10: flag clear paths
    set_cnt(0, 16'hFFFF);
    pulse_tick();
    check("R10 flag set", {15'h0, flag[0]}, 16'h0001);
    wr(8'h01, 8'h05);
    check("R10 write one keeps flag", {15'h0, flag[0]}, 16'h0001);
    ack[0] = 1'b1;
    @(negedge clk);
    ack[0] = 1'b0;
    check("R10 ack clears", {15'h0, flag[0]}, 16'h0000);
    set_cnt(0, 16'hFFFF);
    pulse_tick();
    wr(8'h01, 8'h01);
    check("R10 write zero clears", {15'h0, flag[0]}, 16'h0000);
    set_cnt(0, 16'hFFFF);
    tick = 1'b1; ack[0] = 1'b1;
    @(negedge clk);
    tick = 1'b0; ack[0] = 1'b0;
    check("R10 overflow beats ack", {15'h0, flag[0]}, 16'h0001);

    // R11: write priority and readback
    set_cnt(0, 16'h0010);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'h20;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd16(0, v);
    check("R11 write beats count", v, 16'h0020);
    wr(8'h01, 8'h00);
    set_rld(1, 16'hA55A);
    rd(4'd9, b);
    check("R11 reload low readback", {8'h0, b}, 16'h005A);
    rd(4'd10, b);
    check("R11 reload high readback", {8'h0, b}, 16'h00A5);
    rd(4'd0, b);
    check("R11 config readback", {8'h0, b}, 16'h0001);

    finish_run();
  end
endmodule